// File: doc/BRIEF.md
# Instruction Namespace Control Register with Trap Swap

This block holds the hidden instruction-namespace value for one privilege level. The instruction decoder appends that value to every fetched opcode. Two companion registers sit beside it: a saved copy and a trap-handler value. Software reaches all three through a CSR-style port. Every write is checked against a set of supported encodings that is fixed by parameters. Writes are write-legal/read-legal. An unsupported value is never adjusted. It is refused, the register keeps its old contents, and a one-cycle trap request with a fixed cause code goes back to the pipeline.

When the pipeline signals trap entry or trap return, the three registers rotate in a single clock edge. Entry saves the current value and loads the handler value. Return restores the saved value and reloads the saved slot with the handler value. A PC-update grant follows in the next cycle, so the PC never moves before the new namespace is visible. A parameter can replace the single handler value with a table indexed by trap cause. The same cause selects the table entry for both the entry swap and the return swap.

Top module: `ns_ctl_unit`

## Requirements
- R1: After reset, the current, saved and handler registers (every table entry) read zero, `ns_bits` is zero, and `pc_go` and `ill_trap` are low.
- R2: A write with bit 0 = 0 (native mode) is accepted when all of these hold: the page field in bits 5:1 names a page enabled in `PAGE_OK` (field bit 4 set means a custom page); bit 6 (1 = big-endian) is either clear or `BE_OK` is set; and bits 31:24 set only bits present in `CUSTOM_OK`. An accepted write to the current register appears on `ns_bits` in the cycle after the write edge.
- R3: In native mode, a nonzero value anywhere in bits 23:7 makes the write illegal. This covers the reserved span 23:15 and the unassigned span 14:7.
- R4: In native mode, an unsupported page or a custom bit outside `CUSTOM_OK` makes the write illegal.
- R5: A write with bit 0 = 1 (foreign mode) is accepted only when bits 31:8 are zero and the index in bits 7:1 is enabled in `FOREIGN_OK`. Index bit 7 set means a custom architecture.
- R6: An illegal write changes no register. It raises `ill_trap` for exactly one cycle, the cycle after the write edge, with `ill_code` equal to `ILL_CODE`. Otherwise `ill_code` is zero.
- R7: `csr_sel` picks the register for reads and writes: 0 is current, 1 is saved, 2 is handler, and 3 is unassigned. Writes to saved and handler get the same legality check. A write to selector 3 is illegal, and a read of selector 3 returns zero. The read is combinational from the present register contents.
- R8: On a `trap_enter` edge, saved takes the old current value and current takes the handler value, both at that same edge.
- R9: On a `trap_leave` edge, current takes the old saved value and saved takes the handler value, both at that same edge.
- R10: `pc_go` is high in exactly the cycle after each trap-entry or trap-return edge, the first cycle in which the new namespace is visible. It is low in every other cycle.
- R11: With `USE_CAUSE_TABLE` = 1, the handler value used by both swaps is the table entry picked by `trap_cause`, and CSR access to the handler register uses entry `csr_idx`. With `USE_CAUSE_TABLE` = 0, one handler register serves every cause and both index inputs are ignored.
- R12: If both trap inputs are high in one cycle, the entry takes precedence. A CSR write in the same cycle as a trap event is dropped, with no register change from the write and no `ill_trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 2 | Register select for read and write |
| csr_idx | input | CAUSE_W | Handler table entry for CSR access |
| csr_wdata | input | 32 | Write value |
| csr_rdata | output | 32 | Read value of the selected register |
| trap_enter | input | 1 | Trap entry event |
| trap_leave | input | 1 | Trap return event |
| trap_cause | input | CAUSE_W | Cause of the trap event |
| ns_bits | output | 32 | Current namespace for the decoder |
| pc_go | output | 1 | PC-update grant after a swap |
| ill_trap | output | 1 | Illegal-write trap request |
| ill_code | output | CODE_W | Cause code for the illegal-write trap |

## Verification
The bench builds two copies of the block side by side and feeds them identical stimulus. One uses the cause-indexed handler table with four entries. The other uses the single handler register. Both use the default legality masks: pages 0 to 3 and custom page 16, big-endian allowed, custom bits 27:24, and foreign indices 0, 1 and 64. Running the two copies together shows that the table copy picks a different handler value per cause, while the single copy applies its one handler value to every cause. Each of these legality masks has both an accepted and a refused encoding within reach of the stimulus.

// File: rtl/ns_pkg.sv
package ns_pkg;
   localparam int NS_W       = 32;
   localparam int MODE_BIT   = 0;
   localparam int PAGE_LSB   = 1;
   localparam int PAGE_W     = 5;
   localparam int ENDIAN_BIT = 6;
   localparam int RSV_LO     = 7;
   localparam int RSV_HI     = 23;
   localparam int CUST_LSB   = 24;
   localparam int CUST_W     = 8;
   localparam int FGN_LSB    = 1;
   localparam int FGN_W      = 7;
   localparam int FGN_TOP    = FGN_LSB + FGN_W;
   localparam int NUM_PAGES  = 1 << PAGE_W;
   localparam int NUM_FGN    = 1 << FGN_W;

   typedef enum logic [1:0] {
      SEL_CUR   = 2'd0,
      SEL_SAVED = 2'd1,
      SEL_TRAP  = 2'd2,
      SEL_NONE  = 2'd3
   } ns_sel_e;

   typedef logic [NS_W-1:0] ns_word_t;
endpackage

// File: rtl/ns_legal_chk.sv
module ns_legal_chk
   import ns_pkg::*;
#(
   parameter logic [NUM_PAGES-1:0] PAGE_OK    = 32'h0001_000F,
   parameter bit                   BE_OK      = 1'b1,
   parameter logic [CUST_W-1:0]    CUSTOM_OK  = 8'h0F,
   parameter logic [NUM_FGN-1:0]   FOREIGN_OK = 128'h1_0000_0000_0000_0003
) (
   input  ns_word_t value,
   output logic     legal
);
   logic [PAGE_W-1:0] page;
   logic [FGN_W-1:0]  fidx;
   logic              native_ok;
   logic              foreign_ok;

   always_comb begin
      page = value[PAGE_LSB +: PAGE_W];
      fidx = value[FGN_LSB +: FGN_W];
      native_ok = PAGE_OK[page]
                  && (BE_OK || !value[ENDIAN_BIT])
                  && (value[RSV_HI:RSV_LO] == '0)
                  && ((value[CUST_LSB +: CUST_W] & ~CUSTOM_OK) == '0);
      foreign_ok = FOREIGN_OK[fidx] && (value[NS_W-1:FGN_TOP] == '0);
      legal = value[MODE_BIT] ? foreign_ok : native_ok;
   end
endmodule

// File: rtl/ns_trap_store.sv
module ns_trap_store
   import ns_pkg::*;
#(
   parameter int CAUSE_W   = 2,
   parameter bit USE_TABLE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [CAUSE_W-1:0] widx,
   input  ns_word_t           wdata,
   input  logic [CAUSE_W-1:0] ridx_csr,
   input  logic [CAUSE_W-1:0] ridx_evt,
   output ns_word_t           rd_csr,
   output ns_word_t           rd_evt
);
   localparam int DEPTH = 1 << CAUSE_W;

   if (CAUSE_W < 1 || CAUSE_W > 6) begin : g_bad_w
      $error("ns_trap_store: CAUSE_W out of range");
   end

   if (USE_TABLE) begin : g_tbl
      ns_word_t tbl_q [DEPTH];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
         end else if (we) begin
            tbl_q[widx] <= wdata;
         end
      end
      assign rd_csr = tbl_q[ridx_csr];
      assign rd_evt = tbl_q[ridx_evt];
   end else begin : g_one
      ns_word_t one_q;
      logic     unused_idx;
      assign unused_idx = ^{widx, ridx_csr, ridx_evt};
      always_ff @(posedge clk) begin
         if (!rst_n)  one_q <= '0;
         else if (we) one_q <= wdata;
      end
      assign rd_csr = one_q;
      assign rd_evt = one_q;

      p_one_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !we |=> $stable(one_q));
   end
endmodule

// File: rtl/ns_ctl_unit.sv
module ns_ctl_unit
   import ns_pkg::*;
#(
   parameter int                   CAUSE_W         = 2,
   parameter bit                   USE_CAUSE_TABLE = 1'b0,
   parameter logic [NUM_PAGES-1:0] PAGE_OK         = 32'h0001_000F,
   parameter bit                   BE_OK           = 1'b1,
   parameter logic [CUST_W-1:0]    CUSTOM_OK       = 8'h0F,
   parameter logic [NUM_FGN-1:0]   FOREIGN_OK      = 128'h1_0000_0000_0000_0003,
   parameter int                   CODE_W          = 5,
   parameter logic [CODE_W-1:0]    ILL_CODE        = 5'd2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csr_we,
   input  logic [1:0]         csr_sel,
   input  logic [CAUSE_W-1:0] csr_idx,
   input  logic [NS_W-1:0]    csr_wdata,
   output logic [NS_W-1:0]    csr_rdata,
   input  logic               trap_enter,
   input  logic               trap_leave,
   input  logic [CAUSE_W-1:0] trap_cause,
   output logic [NS_W-1:0]    ns_bits,
   output logic               pc_go,
   output logic               ill_trap,
   output logic [CODE_W-1:0]  ill_code
);
   if (!PAGE_OK[0]) begin : g_bad_reset
      $error("ns_ctl_unit: page 0 must be supported, it is the reset value");
   end
   if (ILL_CODE == '0) begin : g_bad_code
      $error("ns_ctl_unit: ILL_CODE must be nonzero");
   end

   ns_word_t ns_q, last_q;
   ns_word_t trap_csr, trap_evt;
   logic     wr_legal;
   logic     evt;
   logic     wr_take;
   logic     wr_bad;
   logic     pc_go_q, ill_q;
   ns_sel_e  sel;

   assign sel = ns_sel_e'(csr_sel);

   ns_legal_chk #(
      .PAGE_OK(PAGE_OK), .BE_OK(BE_OK),
      .CUSTOM_OK(CUSTOM_OK), .FOREIGN_OK(FOREIGN_OK)
   ) chk_i (
      .value(csr_wdata),
      .legal(wr_legal)
   );

   assign evt     = trap_enter | trap_leave;
   assign wr_take = csr_we && !evt && wr_legal && (sel != SEL_NONE);
   assign wr_bad  = csr_we && !evt && (!wr_legal || (sel == SEL_NONE));

   ns_trap_store #(
      .CAUSE_W(CAUSE_W), .USE_TABLE(USE_CAUSE_TABLE)
   ) store_i (
      .clk(clk), .rst_n(rst_n),
      .we(wr_take && (sel == SEL_TRAP)),
      .widx(csr_idx), .wdata(csr_wdata),
      .ridx_csr(csr_idx), .ridx_evt(trap_cause),
      .rd_csr(trap_csr), .rd_evt(trap_evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ns_q   <= '0;
         last_q <= '0;
      end else if (trap_enter) begin
         last_q <= ns_q;
         ns_q   <= trap_evt;
      end else if (trap_leave) begin
         ns_q   <= last_q;
         last_q <= trap_evt;
      end else if (wr_take && sel == SEL_CUR) begin
         ns_q <= csr_wdata;
      end else if (wr_take && sel == SEL_SAVED) begin
         last_q <= csr_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_go_q <= 1'b0;
         ill_q   <= 1'b0;
      end else begin
         pc_go_q <= evt;
         ill_q   <= wr_bad;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_CUR:   csr_rdata = ns_q;
         SEL_SAVED: csr_rdata = last_q;
         SEL_TRAP:  csr_rdata = trap_csr;
         default:   csr_rdata = '0;
      endcase
   end

   assign ns_bits  = ns_q;
   assign pc_go    = pc_go_q;
   assign ill_trap = ill_q;
   assign ill_code = ill_q ? ILL_CODE : '0;

   p_entry_saves_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_enter |=> (last_q == $past(ns_q)) && (ns_q == $past(trap_evt)));
   p_exit_restores_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_leave && !trap_enter) |=> (ns_q == $past(last_q)) && (last_q == $past(trap_evt)));
   p_pc_after_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> pc_go);
   p_pc_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !evt |=> !pc_go);
   p_ill_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ill_trap |-> $stable(ns_q) && $stable(last_q));
   p_event_no_ill_r12: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !ill_trap);
endmodule

// File: tb/ns_ctl_unit_tb_top.sv
`timescale 1ns/1ps
module ns_ctl_unit_tb_top;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        csr_we = 0;
   logic [1:0]  csr_sel = 0;
   logic [1:0]  csr_idx = 0;
   logic [31:0] csr_wdata = 0;
   logic        trap_enter = 0, trap_leave = 0;
   logic [1:0]  trap_cause = 0;
   logic [31:0] rd_a, ns_a, rd_b, ns_b;
   logic        go_a, ill_a, go_b, ill_b;
   logic [4:0]  code_a, code_b;

   always #2 clk = ~clk;

   ns_ctl_unit #(.CAUSE_W(2), .USE_CAUSE_TABLE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
      .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(rd_a),
      .trap_enter(trap_enter), .trap_leave(trap_leave), .trap_cause(trap_cause),
      .ns_bits(ns_a), .pc_go(go_a), .ill_trap(ill_a), .ill_code(code_a));

   ns_ctl_unit #(.CAUSE_W(2), .USE_CAUSE_TABLE(1'b0)) dut_b (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
      .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(rd_b),
      .trap_enter(trap_enter), .trap_leave(trap_leave), .trap_cause(trap_cause),
      .ns_bits(ns_b), .pc_go(go_b), .ill_trap(ill_b), .ill_code(code_b));

   typedef struct {
      logic [31:0] ns_a, ns_b, rd_a, rd_b;
      bit          go, ill;
      string       req;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errs = 0;
   bit   done = 0;

   logic [31:0] m_ns_a = 0, m_last_a = 0, m_ns_b = 0, m_last_b = 0, m_ts = 0;
   logic [31:0] m_tbl [4] = '{default: 0};

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: pops one expected item per cycle, after the edge
   always @(posedge clk) begin
      #1;
      if (!done && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(e.req, "ns_bits table copy", ns_a, e.ns_a);
         chk(e.req, "ns_bits single copy", ns_b, e.ns_b);
         chk(e.req, "csr_rdata table copy", rd_a, e.rd_a);
         chk(e.req, "csr_rdata single copy", rd_b, e.rd_b);
         chk(e.req, "pc_go", {31'd0, go_a}, {31'd0, e.go});
         chk(e.req, "pc_go single copy", {31'd0, go_b}, {31'd0, e.go});
         chk(e.req, "ill_trap", {31'd0, ill_a}, {31'd0, e.ill});
         chk(e.req, "ill_code", {27'd0, code_a}, e.ill ? 32'd2 : 32'd0);
         chk(e.req, "ill_code single copy", {27'd0, code_b}, e.ill ? 32'd2 : 32'd0);
      end
   end

   // driver: one cycle of stimulus, pushes the outputs expected after the edge
   task automatic step(input bit we, input logic [1:0] sel, input logic [1:0] idx,
                       input logic [31:0] d, input bit bad, input bit en, input bit lv,
                       input logic [1:0] cause, input string req);
      exp_t e;
      logic [31:0] ta;
      bit ev;
      csr_we = we; csr_sel = sel; csr_idx = idx; csr_wdata = d;
      trap_enter = en; trap_leave = lv; trap_cause = cause;
      ev = en | lv;
      ta = m_tbl[cause];
      if (en) begin
         m_last_a = m_ns_a; m_ns_a = ta;
         m_last_b = m_ns_b; m_ns_b = m_ts;
      end else if (lv) begin
         m_ns_a = m_last_a; m_last_a = ta;
         m_ns_b = m_last_b; m_last_b = m_ts;
      end else if (we && !bad && sel != 2'd3) begin
         case (sel)
            2'd0: begin m_ns_a = d; m_ns_b = d; end
            2'd1: begin m_last_a = d; m_last_b = d; end
            default: begin m_tbl[idx] = d; m_ts = d; end
         endcase
      end
      e.ns_a = m_ns_a;
      e.ns_b = m_ns_b;
      case (sel)
         2'd0: begin e.rd_a = m_ns_a; e.rd_b = m_ns_b; end
         2'd1: begin e.rd_a = m_last_a; e.rd_b = m_last_b; end
         2'd2: begin e.rd_a = m_tbl[idx]; e.rd_b = m_ts; end
         default: begin e.rd_a = 0; e.rd_b = 0; end
      endcase
      e.go = ev;
      e.ill = we && !ev && bad;
      e.req = req;
      q.push_back(e);
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(4 * 20000);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         done = 1;
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state of all registers
      step(0, 2'd0, 2'd0, 0, 0, 0, 0, 0, "R1");
      step(0, 2'd1, 2'd0, 0, 0, 0, 0, 0, "R1");
      step(0, 2'd2, 2'd3, 0, 0, 0, 0, 0, "R1");
      // R2: native page 2, big-endian
      step(1, 2'd0, 2'd0, 32'h0000_0044, 0, 0, 0, 0, "R2");
      // R4: unsupported page 4
      step(1, 2'd0, 2'd0, 32'h0000_0008, 1, 0, 0, 0, "R4");
      step(0, 2'd0, 2'd0, 0, 0, 0, 0, 0, "R6");
      // R3: reserved and unassigned bits
      step(1, 2'd0, 2'd0, 32'h0000_8044, 1, 0, 0, 0, "R3");
      step(1, 2'd0, 2'd0, 32'h0000_0244, 1, 0, 0, 0, "R3");
      step(1, 2'd0, 2'd0, 32'h0080_0044, 1, 0, 0, 0, "R3");
      // R2 custom bits allowed, R4 custom bit not allowed
      step(1, 2'd0, 2'd0, 32'h0300_0044, 0, 0, 0, 0, "R2");
      step(1, 2'd0, 2'd0, 32'h1000_0044, 1, 0, 0, 0, "R4");
      // R11/R7: handler table writes, R5 foreign encodings
      step(1, 2'd2, 2'd0, 32'h0000_0020, 0, 0, 0, 0, "R11");
      step(1, 2'd2, 2'd1, 32'h0000_0081, 0, 0, 0, 0, "R5");
      step(1, 2'd2, 2'd3, 32'h0000_0005, 1, 0, 0, 0, "R5");
      step(1, 2'd2, 2'd3, 32'h0000_0103, 1, 0, 0, 0, "R5");
      step(0, 2'd2, 2'd3, 0, 0, 0, 0, 0, "R6");
      step(1, 2'd2, 2'd2, 32'h0000_0003, 0, 0, 0, 0, "R11");
      step(0, 2'd2, 2'd0, 0, 0, 0, 0, 0, "R11");
      // R7: saved register, unassigned selector
      step(1, 2'd1, 2'd0, 32'h0000_0002, 0, 0, 0, 0, "R7");
      step(1, 2'd1, 2'd0, 32'h0000_0008, 1, 0, 0, 0, "R7");
      step(1, 2'd3, 2'd0, 32'h0000_0002, 1, 0, 0, 0, "R7");
      step(0, 2'd1, 2'd0, 0, 0, 0, 0, 0, "R7");
      // R8/R10/R11: entry with cause 1
      step(0, 2'd1, 2'd0, 0, 0, 1, 0, 2'd1, "R8");
      step(0, 2'd0, 2'd0, 0, 0, 0, 0, 0, "R10");
      // R9/R11: return with cause 2
      step(0, 2'd1, 2'd0, 0, 0, 0, 1, 2'd2, "R9");
      step(0, 2'd0, 2'd0, 0, 0, 0, 0, 0, "R10");
      // R12: both events, entry wins
      step(0, 2'd1, 2'd0, 0, 0, 1, 1, 2'd0, "R12");
      // R12: writes dropped during events, illegal or legal
      step(1, 2'd0, 2'd0, 32'h0000_0008, 1, 0, 1, 2'd0, "R12");
      step(1, 2'd0, 2'd0, 32'h0000_0002, 0, 1, 0, 2'd1, "R12");
      step(0, 2'd1, 2'd0, 0, 0, 0, 0, 0, "R12");
      step(0, 2'd2, 2'd1, 0, 0, 0, 0, 0, "R11");
      repeat (3) @(negedge clk);
      if (q.size() != 0) begin
         errs++;
         $display("FAIL scoreboard: actual=%0d expected=0 items left", q.size());
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule